// File: doc/BRIEF.md
# Predicate Register File with Commit Gating

This block keeps a bank of one-bit predicate registers and uses them to decide, at the commit stage, whether a retiring instruction takes effect. Compare operations on two wide operands write a boolean outcome into one predicate and its complement into another. Logic operations fold two existing predicates together with AND or OR, so that a condition built from several tests ends up in a single predicate.

Every retiring instruction names a qualifying predicate. If that predicate reads true, the instruction's register write and any pending exception go out on the commit port one cycle later. If it reads false, the instruction is annulled. It then writes nothing and raises nothing, exactly like a no-op. The decision is taken at commit, not at issue. A compare in the same cycle as the retire is applied first, so a predicate produced just ahead of its consumer still gates it correctly.

Top module: `pred_commit_gate`

## Requirements
- R1: After synchronous reset every predicate except index 0 holds false, and the commit outputs com_wr_en, com_exc and com_annul are low.
- R2: Predicate index 0 always reads true. A compare or logic write aimed at index 0 leaves it true.
- R3: The 2-bit cmp_cond selects the test: 00 equal, 01 not equal, 10 signed less-than, 11 unsigned less-than. Operands are cmp_a and cmp_b, and the test is cmp_a OP cmp_b.
- R4: A compare writes its outcome to predicate cmp_dst_t and the complement to cmp_dst_f, both at the same clock edge.
- R5: When cmp_dst_t and cmp_dst_f name the same nonzero predicate, that predicate receives the outcome, not its complement.
- R6: A logic operation writes plog_dst with the AND (plog_or=0) or the OR (plog_or=1) of the values stored in plog_src_a and plog_src_b before that edge. If a compare destination in the same cycle names the same predicate, the compare wins.
- R7: A retire whose qualifying predicate is true drives com_wr_en (if ret_wr_en), com_wr_idx and com_wr_data, and com_exc (if ret_exc), one cycle after it is presented.
- R8: A retire whose qualifying predicate is false raises com_annul one cycle later. In that cycle com_wr_en and com_exc stay low.
- R9: A compare or logic write and a retire in the same cycle are ordered write first. The retire is gated by the newly written predicate value.
- R10: In a cycle after one with no retire, and after a true-predicate retire carrying neither write nor exception, com_wr_en, com_exc and com_annul are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmp_valid | input | 1 | Compare request this cycle |
| cmp_cond | input | 2 | Compare condition code |
| cmp_a | input | DATA_W | First compare operand |
| cmp_b | input | DATA_W | Second compare operand |
| cmp_dst_t | input | PIDX_W | Predicate receiving the compare outcome |
| cmp_dst_f | input | PIDX_W | Predicate receiving the complement |
| plog_valid | input | 1 | Predicate logic request this cycle |
| plog_or | input | 1 | 0 = AND, 1 = OR |
| plog_src_a | input | PIDX_W | First source predicate |
| plog_src_b | input | PIDX_W | Second source predicate |
| plog_dst | input | PIDX_W | Destination predicate |
| ret_valid | input | 1 | Instruction retiring this cycle |
| ret_qp | input | PIDX_W | Qualifying predicate index |
| ret_wr_en | input | 1 | Instruction requests a register write |
| ret_wr_idx | input | GIDX_W | Destination register index |
| ret_wr_data | input | DATA_W | Write data |
| ret_exc | input | 1 | Instruction carries a pending exception |
| com_wr_en | output | 1 | Committed register write strobe |
| com_wr_idx | output | GIDX_W | Committed write index |
| com_wr_data | output | DATA_W | Committed write data |
| com_exc | output | 1 | Committed exception |
| com_annul | output | 1 | Instruction annulled |

## Verification
The bench builds the block with its defaults: 64 predicates, 64-bit operands and 7-bit register indices. This puts the top predicate index 63 and operand bit 63 within reach. The signed and unsigned less-than tests can therefore disagree on an all-ones operand, and writes to the last predicate exercise the full index width. A scoreboard models the bank and the compare-first ordering independently and predicts each commit-port cycle.

// File: rtl/pcg_pkg.sv
// Shared types for the predicate commit-gating block.
package pcg_pkg;
    typedef enum logic [1:0] {
        CMP_EQ  = 2'b00,
        CMP_NE  = 2'b01,
        CMP_SLT = 2'b10,
        CMP_ULT = 2'b11
    } cmp_cond_e;

    typedef enum logic {
        PL_AND = 1'b0,
        PL_OR  = 1'b1
    } plog_fn_e;

    typedef struct packed {
        logic wr_en;
        logic exc;
        logic annul;
    } commit_flags_t;
endpackage

// File: rtl/pcg_cond_eval.sv
// Compare evaluator: reduces two operands to one boolean under a condition code.
// Assumes operands are two's complement for the signed test. Purely combinational.
module pcg_cond_eval
    import pcg_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  logic [1:0]        cond,
    input  logic [DATA_W-1:0] opa,
    input  logic [DATA_W-1:0] opb,
    output logic              result
);
    // Select the test named by the condition code.
    always_comb begin
        unique case (cmp_cond_e'(cond))
            CMP_EQ:  result = (opa == opb);
            CMP_NE:  result = (opa != opb);
            CMP_SLT: result = ($signed(opa) < $signed(opb));
            default: result = (opa < opb);
        endcase
    end
endmodule

// File: rtl/pcg_pred_logic.sv
// Predicate combiner: AND or OR of two predicate bits.
// Assumes sources are already-read predicate values. Purely combinational.
module pcg_pred_logic
    import pcg_pkg::*;
(
    input  logic fn,
    input  logic pa,
    input  logic pb,
    output logic y
);
    // Apply the selected boolean operator.
    always_comb begin
        unique case (plog_fn_e'(fn))
            PL_AND:  y = pa & pb;
            default: y = pa | pb;
        endcase
    end
endmodule

// File: rtl/pcg_pred_bank.sv
// Predicate storage with two write sources and forwarding to the qualifying read.
// Write priority per entry: compare true-destination, compare false-destination,
// then logic destination. Entry 0 is constant true. The qualifying-predicate read
// sees the value after this cycle's writes; the logic sources read stored values.
// Assumes NPRED is a power of two so every index is in range.
module pcg_pred_bank #(
    parameter int NPRED  = 64,
    parameter int PIDX_W = $clog2(NPRED)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmp_we,
    input  logic [PIDX_W-1:0] cmp_dt,
    input  logic [PIDX_W-1:0] cmp_df,
    input  logic              cmp_res,
    input  logic              pl_we,
    input  logic [PIDX_W-1:0] pl_dst,
    input  logic              pl_val,
    input  logic [PIDX_W-1:0] src_a,
    input  logic [PIDX_W-1:0] src_b,
    output logic              src_a_val,
    output logic              src_b_val,
    input  logic [PIDX_W-1:0] qp_idx,
    output logic              qp_val
);
    logic [NPRED-1:0] pred_q;
    logic [NPRED-1:0] pred_d;

    // Form the next bank state, applying write priority per entry.
    always_comb begin
        pred_d = pred_q;
        for (int i = 1; i < NPRED; i++) begin
            if (cmp_we && cmp_dt == PIDX_W'(i))
                pred_d[i] = cmp_res;
            else if (cmp_we && cmp_df == PIDX_W'(i))
                pred_d[i] = ~cmp_res;
            else if (pl_we && pl_dst == PIDX_W'(i))
                pred_d[i] = pl_val;
        end
        pred_d[0] = 1'b1;
    end

    // Hold the bank; reset clears all entries but the constant-true one.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pred_q <= NPRED'(1);
        else
            pred_q <= pred_d;
    end

    // Read ports: logic sources see stored state, qualifier sees forwarded state.
    always_comb begin
        src_a_val = pred_q[src_a];
        src_b_val = pred_q[src_b];
        qp_val    = pred_d[qp_idx];
    end
endmodule

// File: rtl/pcg_retire_gate.sv
// Commit gate: turns a retiring instruction plus its qualifying predicate value
// into a registered commit or annulment, one cycle later. Write index and data
// update only when a write commits, and hold otherwise.
module pcg_retire_gate
    import pcg_pkg::*;
#(
    parameter int GIDX_W = 7,
    parameter int DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ret_valid,
    input  logic              qp_val,
    input  logic              ret_wr_en,
    input  logic [GIDX_W-1:0] ret_wr_idx,
    input  logic [DATA_W-1:0] ret_wr_data,
    input  logic              ret_exc,
    output logic              com_wr_en,
    output logic [GIDX_W-1:0] com_wr_idx,
    output logic [DATA_W-1:0] com_wr_data,
    output logic              com_exc,
    output logic              com_annul
);
    commit_flags_t flags_d, flags_q;

    // Decide commit or annul for this cycle's retire.
    always_comb begin
        flags_d.wr_en = ret_valid & qp_val & ret_wr_en;
        flags_d.exc   = ret_valid & qp_val & ret_exc;
        flags_d.annul = ret_valid & ~qp_val;
    end

    // Register the outcome strobes.
    always_ff @(posedge clk) begin
        if (!rst_n)
            flags_q <= '0;
        else
            flags_q <= flags_d;
    end

    // Capture the write payload only when a write commits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            com_wr_idx  <= '0;
            com_wr_data <= '0;
        end else if (flags_d.wr_en) begin
            com_wr_idx  <= ret_wr_idx;
            com_wr_data <= ret_wr_data;
        end
    end

    assign com_wr_en = flags_q.wr_en;
    assign com_exc   = flags_q.exc;
    assign com_annul = flags_q.annul;
endmodule

// File: rtl/pred_commit_gate.sv
// Top: predicate register file with commit-stage gating.
// Compare and logic writes land at the clock edge; a retire in the same cycle is
// gated by the post-write predicate value. Outputs are registered (one cycle).
module pred_commit_gate #(
    parameter int NPRED  = 64,
    parameter int DATA_W = 64,
    parameter int GIDX_W = 7,
    localparam int PIDX_W = $clog2(NPRED)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmp_valid,
    input  logic [1:0]        cmp_cond,
    input  logic [DATA_W-1:0] cmp_a,
    input  logic [DATA_W-1:0] cmp_b,
    input  logic [PIDX_W-1:0] cmp_dst_t,
    input  logic [PIDX_W-1:0] cmp_dst_f,
    input  logic              plog_valid,
    input  logic              plog_or,
    input  logic [PIDX_W-1:0] plog_src_a,
    input  logic [PIDX_W-1:0] plog_src_b,
    input  logic [PIDX_W-1:0] plog_dst,
    input  logic              ret_valid,
    input  logic [PIDX_W-1:0] ret_qp,
    input  logic              ret_wr_en,
    input  logic [GIDX_W-1:0] ret_wr_idx,
    input  logic [DATA_W-1:0] ret_wr_data,
    input  logic              ret_exc,
    output logic              com_wr_en,
    output logic [GIDX_W-1:0] com_wr_idx,
    output logic [DATA_W-1:0] com_wr_data,
    output logic              com_exc,
    output logic              com_annul
);
    logic cmp_res;
    logic pa_val, pb_val, pl_val;
    logic qp_val;

    pcg_cond_eval #(.DATA_W(DATA_W)) u_cond (
        .cond   (cmp_cond),
        .opa    (cmp_a),
        .opb    (cmp_b),
        .result (cmp_res)
    );

    pcg_pred_logic u_plog (
        .fn (plog_or),
        .pa (pa_val),
        .pb (pb_val),
        .y  (pl_val)
    );

    pcg_pred_bank #(.NPRED(NPRED), .PIDX_W(PIDX_W)) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmp_we    (cmp_valid),
        .cmp_dt    (cmp_dst_t),
        .cmp_df    (cmp_dst_f),
        .cmp_res   (cmp_res),
        .pl_we     (plog_valid),
        .pl_dst    (plog_dst),
        .pl_val    (pl_val),
        .src_a     (plog_src_a),
        .src_b     (plog_src_b),
        .src_a_val (pa_val),
        .src_b_val (pb_val),
        .qp_idx    (ret_qp),
        .qp_val    (qp_val)
    );

    pcg_retire_gate #(.GIDX_W(GIDX_W), .DATA_W(DATA_W)) u_gate (
        .clk         (clk),
        .rst_n       (rst_n),
        .ret_valid   (ret_valid),
        .qp_val      (qp_val),
        .ret_wr_en   (ret_wr_en),
        .ret_wr_idx  (ret_wr_idx),
        .ret_wr_data (ret_wr_data),
        .ret_exc     (ret_exc),
        .com_wr_en   (com_wr_en),
        .com_wr_idx  (com_wr_idx),
        .com_wr_data (com_wr_data),
        .com_exc     (com_exc),
        .com_annul   (com_annul)
    );
endmodule

// File: rtl/pcg_checker.sv
// Port-level properties of the commit gate, attached to the top by bind.
module pcg_checker #(
    parameter int PIDX_W = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ret_valid,
    input logic [PIDX_W-1:0] ret_qp,
    input logic              ret_wr_en,
    input logic              com_wr_en,
    input logic              com_exc,
    input logic              com_annul
);
    // R8: an annulled instruction neither writes nor raises.
    a_r8_annul_silent: assert property (@(posedge clk) disable iff (!rst_n)
        com_annul |-> (!com_wr_en && !com_exc));

    // R10: no retire, no commit activity next cycle.
    a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !ret_valid |=> (!com_wr_en && !com_exc && !com_annul));

    // R2: predicate 0 never annuls.
    a_r2_p0_true: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_valid && ret_qp == '0) |=> !com_annul);

    // R7: a retire with a write request either commits it or is annulled.
    a_r7_write_resolved: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_valid && ret_wr_en) |=> (com_wr_en || com_annul));

    // R8: commit and annul are mutually exclusive.
    a_r8_outcome_excl: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({com_wr_en, com_annul}));
endmodule

bind pred_commit_gate pcg_checker #(.PIDX_W(PIDX_W)) u_pcg_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ret_valid (ret_valid),
    .ret_qp    (ret_qp),
    .ret_wr_en (ret_wr_en),
    .com_wr_en (com_wr_en),
    .com_exc   (com_exc),
    .com_annul (com_annul)
);

// File: tb/tb_pred_commit_gate.sv
// Scoreboard bench: the driver applies one cycle of stimulus, updates a bench-side
// predicate model and queues the expected commit outcome; the monitor pops and
// compares one item per clock, shortly after the edge.
module tb_pred_commit_gate;
    localparam int CLK_PERIOD = 10;
    localparam int NPRED  = 64;
    localparam int DATA_W = 64;
    localparam int GIDX_W = 7;
    localparam int PIDX_W = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic              cmp_valid;
    logic [1:0]        cmp_cond;
    logic [DATA_W-1:0] cmp_a, cmp_b;
    logic [PIDX_W-1:0] cmp_dst_t, cmp_dst_f;
    logic              plog_valid, plog_or;
    logic [PIDX_W-1:0] plog_src_a, plog_src_b, plog_dst;
    logic              ret_valid;
    logic [PIDX_W-1:0] ret_qp;
    logic              ret_wr_en;
    logic [GIDX_W-1:0] ret_wr_idx;
    logic [DATA_W-1:0] ret_wr_data;
    logic              ret_exc;
    logic              com_wr_en, com_exc, com_annul;
    logic [GIDX_W-1:0] com_wr_idx;
    logic [DATA_W-1:0] com_wr_data;

    pred_commit_gate #(.NPRED(NPRED), .DATA_W(DATA_W), .GIDX_W(GIDX_W)) dut (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    bit [NPRED-1:0] model;
    logic [2+GIDX_W+DATA_W:0] exp_q[$];
    string tag_q[$];

    function automatic bit eval_cmp(bit [1:0] c, bit [DATA_W-1:0] a, bit [DATA_W-1:0] b);
        case (c)
            2'b00:   return a == b;
            2'b01:   return a != b;
            2'b10:   return $signed(a) < $signed(b);
            default: return a < b;
        endcase
    endfunction

    task automatic idle_in();
        cmp_valid = 0; cmp_cond = 0; cmp_a = 0; cmp_b = 0; cmp_dst_t = 0; cmp_dst_f = 0;
        plog_valid = 0; plog_or = 0; plog_src_a = 0; plog_src_b = 0; plog_dst = 0;
        ret_valid = 0; ret_qp = 0; ret_wr_en = 0; ret_wr_idx = 0; ret_wr_data = 0; ret_exc = 0;
    endtask

    task automatic set_cmp(bit [1:0] c, bit [DATA_W-1:0] a, bit [DATA_W-1:0] b, int dt, int df);
        cmp_valid = 1; cmp_cond = c; cmp_a = a; cmp_b = b;
        cmp_dst_t = PIDX_W'(dt); cmp_dst_f = PIDX_W'(df);
    endtask

    task automatic set_pl(bit f, int sa, int sb, int d);
        plog_valid = 1; plog_or = f;
        plog_src_a = PIDX_W'(sa); plog_src_b = PIDX_W'(sb); plog_dst = PIDX_W'(d);
    endtask

    task automatic set_ret(int qp, bit we, int idx, bit [DATA_W-1:0] d, bit ex);
        ret_valid = 1; ret_qp = PIDX_W'(qp); ret_wr_en = we;
        ret_wr_idx = GIDX_W'(idx); ret_wr_data = d; ret_exc = ex;
    endtask

    // Driver side: update the model for this cycle's stimulus and queue the outcome.
    task automatic push(string tag);
        bit [NPRED-1:0] nxt;
        bit r, q;
        nxt = model;
        if (plog_valid && plog_dst != 0)
            nxt[plog_dst] = plog_or ? (model[plog_src_a] | model[plog_src_b])
                                    : (model[plog_src_a] & model[plog_src_b]);
        if (cmp_valid) begin
            r = eval_cmp(cmp_cond, cmp_a, cmp_b);
            if (cmp_dst_f != 0) nxt[cmp_dst_f] = ~r;
            if (cmp_dst_t != 0) nxt[cmp_dst_t] = r;
        end
        nxt[0] = 1'b1;
        model = nxt;
        q = model[ret_qp];
        exp_q.push_back({ret_valid & q & ret_wr_en, ret_valid & q & ret_exc,
                         ret_valid & ~q, ret_wr_idx, ret_wr_data});
        tag_q.push_back(tag);
    endtask

    // Monitor: compare one queued outcome per clock, away from the edge.
    always @(posedge clk) begin
        #1;
        if (exp_q.size() > 0) begin
            logic [2+GIDX_W+DATA_W:0] e;
            string t;
            bit bad;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            checks++;
            bad = ({com_wr_en, com_exc, com_annul} != e[2+GIDX_W+DATA_W -: 3]);
            if (e[2+GIDX_W+DATA_W] && ({com_wr_idx, com_wr_data} != e[GIDX_W+DATA_W-1:0]))
                bad = 1;
            if (bad) begin
                fails++;
                $display("FAIL %s: got we=%0b exc=%0b annul=%0b idx=%0d data=%h, expected we=%0b exc=%0b annul=%0b idx=%0d data=%h",
                    t, com_wr_en, com_exc, com_annul, com_wr_idx, com_wr_data,
                    e[2+GIDX_W+DATA_W], e[1+GIDX_W+DATA_W], e[GIDX_W+DATA_W],
                    e[GIDX_W+DATA_W-1:DATA_W], e[DATA_W-1:0]);
            end
        end
    end

    task automatic summary();
        $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #(CLK_PERIOD * 50000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got timeout, expected completion");
            summary();
            $finish;
        end
    end

    localparam bit [DATA_W-1:0] ALL1 = '1;

    initial begin
        idle_in();
        model = NPRED'(1);
        repeat (3) @(posedge clk);
        #1;
        checks++;
        if ({com_wr_en, com_exc, com_annul} != 3'b000) begin
            fails++;
            $display("FAIL R1: got flags %b, expected 000", {com_wr_en, com_exc, com_annul});
        end
        @(negedge clk); rst_n = 1'b1;

        // R1 / R8: reset predicate is false, so the retire is annulled silently.
        @(negedge clk); idle_in(); set_ret(5, 1, 9, 64'h11, 1); push("R1 R8 reset-false qp");
        // R2: predicate 0 commits.
        @(negedge clk); idle_in(); set_ret(0, 1, 9, 64'hA5A5, 0); push("R2 p0 commits");
        // R3 / R4: equal true -> p3=1, p4=0.
        @(negedge clk); idle_in(); set_cmp(2'b00, 7, 7, 3, 4); push("R4 compare write");
        @(negedge clk); idle_in(); set_ret(3, 1, 12, 64'h33, 0); push("R4 true dest");
        @(negedge clk); idle_in(); set_ret(4, 1, 12, 64'h44, 1); push("R4 false dest");
        // R9: same-cycle compare (NE false) then retire on it.
        @(negedge clk); idle_in(); set_cmp(2'b01, 7, 7, 5, 6); set_ret(5, 1, 1, 64'h55, 1); push("R9 R3 ne");
        @(negedge clk); idle_in(); set_ret(6, 1, 2, 64'h66, 0); push("R3 ne complement");
        // R3 signed versus unsigned on all-ones.
        @(negedge clk); idle_in(); set_cmp(2'b10, ALL1, 1, 7, 8); set_ret(7, 1, 3, 64'h77, 0); push("R3 slt");
        @(negedge clk); idle_in(); set_cmp(2'b11, ALL1, 1, 9, 10); set_ret(9, 1, 4, 64'h99, 0); push("R3 ult");
        @(negedge clk); idle_in(); set_ret(10, 1, 5, 64'hAA, 0); push("R3 ult complement");
        // R2: compare false to p0 leaves it true.
        @(negedge clk); idle_in(); set_cmp(2'b00, 1, 2, 0, 11); set_ret(0, 1, 6, 64'hB0, 0); push("R2 p0 write ignored");
        @(negedge clk); idle_in(); set_ret(11, 1, 7, 64'hB1, 0); push("R4 df with dt=0");
        // R5: same destination gets the outcome.
        @(negedge clk); idle_in(); set_cmp(2'b00, 3, 3, 12, 12); set_ret(12, 1, 8, 64'hC0, 0); push("R5 same dst true");
        @(negedge clk); idle_in(); set_cmp(2'b00, 3, 4, 13, 13); push("R5 same dst false");
        @(negedge clk); idle_in(); set_ret(13, 1, 8, 64'hC1, 1); push("R5 same dst false read");
        // R6: logic AND / OR of p3=1, p4=0.
        @(negedge clk); idle_in(); set_pl(0, 3, 4, 20); push("R6 and write");
        @(negedge clk); idle_in(); set_ret(20, 1, 9, 64'hD0, 0); push("R6 and result");
        @(negedge clk); idle_in(); set_pl(1, 3, 4, 21); set_ret(21, 1, 10, 64'hD1, 0); push("R6 R9 or result");
        @(negedge clk); idle_in(); set_pl(0, 3, 3, 22); set_cmp(2'b00, 1, 2, 22, 23); set_ret(22, 1, 11, 64'hD2, 0); push("R6 compare wins");
        // R7: top index, exception only.
        @(negedge clk); idle_in(); set_cmp(2'b00, 0, 0, 63, 62); set_ret(63, 0, 0, 0, 1); push("R7 exc commits");
        @(negedge clk); idle_in(); set_ret(62, 0, 0, 0, 1); push("R8 exc suppressed");
        // R10: idle and empty true retire.
        @(negedge clk); idle_in(); push("R10 idle");
        @(negedge clk); idle_in(); set_ret(0, 0, 0, 0, 0); push("R10 empty retire");
        @(negedge clk); idle_in(); set_ret(63, 1, 127, ALL1, 1); push("R7 full commit");
        @(negedge clk); idle_in(); push("R10 idle tail");

        repeat (3) @(posedge clk);
        #2;
        done = 1'b1;
        summary();
        $finish;
    end
endmodule